// File: doc/BRIEF.md
# Conversion Result FIFO with Width-Selected Pop

This block buffers the 10-bit results of hardware-triggered analog conversions until the CPU collects them. The conversion sequencer pushes each result when a conversion finishes. The block can hold up to six results. The CPU reads them through one data register. Each read carries an access-size qualifier. A full-width read consumes the oldest result. A byte-wide read returns the same result and leaves it in place, so software can look at the next value without removing it.

The block reports its occupancy as a count and as empty and full flags. If a result arrives while no space is free, the result is discarded and a sticky overrun flag is raised. The flag is cleared only by reset. The read data output is registered. It presents the result fetched by the most recent read of a non-empty buffer. A read of an empty buffer leaves that value, the pointers and the count unchanged.

Top module: `conv_result_fifo`

## Requirements
- R1: The buffer holds at most 6 results, and `count` gives the number stored (0 to 6).
- R2: Results leave the buffer in the order in which they were pushed.
- R3: A read with `rd_wide`=1 (full-width access) on a non-empty buffer puts the oldest result, zero-extended to 16 bits, on `rd_data` one clock later and removes that result from the buffer.
- R4: A read with `rd_wide`=0 (byte access) on a non-empty buffer puts the oldest result on `rd_data` one clock later and does not remove it. The count and the order of the results stay as they were.
- R5: `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` is 6.
- R6: A push while the buffer is full, with no full-width pop in the same cycle, discards the new result and sets `overrun`. Once set, `overrun` stays at 1 until reset.
- R7: A read of an empty buffer leaves `rd_data` and `count` unchanged.
- R8: A push and a full-width pop in the same cycle on a non-empty buffer both take effect, and `count` does not change. This also holds when the buffer is full.
- R9: After reset, `count` is 0, `empty` is 1, `full` is 0, `overrun` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | A conversion finished; store `push_data` |
| push_data | input | 10 | Conversion result |
| rd_en | input | 1 | CPU read of the data register |
| rd_wide | input | 1 | Access size of the read: 1 = full width (pop), 0 = byte (peek) |
| rd_data | output | 16 | Zero-extended result from the latest read of a non-empty buffer |
| empty | output | 1 | No result stored |
| full | output | 1 | Six results stored |
| count | output | 3 | Number of stored results |
| overrun | output | 1 | Sticky flag: a result was discarded |

## Verification
The assertions assume that `rd_wide` has meaning only while `rd_en` is high. They also assume that push and read requests are single-cycle strobes that are sampled on every clock. The bench drives every combination of push, read and access width in fill-heavy, drain-heavy and mixed phases. This takes the buffer through empty, full, overrun and simultaneous push/pop states. The bench changes inputs only on the falling clock edge, so each request is held stable for one whole cycle around the edge that samples it.

// File: rtl/conv_result_fifo.sv
module conv_result_fifo #(
  parameter int DEPTH = 6,
  parameter int DW    = 10,
  parameter int RW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  input  logic [DW-1:0]                push_data,
  input  logic                         rd_en,
  input  logic                         rd_wide,
  output logic [RW-1:0]                rd_data,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         overrun
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;

  wire peek   = rd_en && !empty;
  wire pop    = peek && rd_wide;
  wire accept = push_valid && (!full || pop);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk)
    if (accept) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
      rd_data <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      if (accept && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !accept) cnt <= cnt - CW'(1);
      if (push_valid && !accept) overrun <= 1'b1;
      if (peek) rd_data <= RW'(mem[rd_ptr]);
    end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full && !(rd_en && rd_wide) |=> overrun);
  // R6
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty && !push_valid |=> $stable(rd_data) && $stable(cnt));
  // R4
  byte_peek_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_wide && !push_valid |=> $stable(cnt));
  // R8
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && rd_en && rd_wide && !empty |=> $stable(cnt));
endmodule

// File: tb/test_conv_result_fifo.sv
module test_conv_result_fifo;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, rd_en = 0, rd_wide = 0;
  logic [9:0] push_data = '0;
  logic [15:0] rd_data;
  logic empty, full, overrun;
  logic [2:0] count;

  conv_result_fifo i_conv_result_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .rd_en(rd_en), .rd_wide(rd_wide), .rd_data(rd_data), .empty(empty),
    .full(full), .count(count), .overrun(overrun));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int mq [6];
  int mcnt = 0, mlast = 0, movr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit p, input int d, input bit r, input bit w);
    bit popped;
    @(negedge clk);
    push_valid = p; push_data = d[9:0]; rd_en = r; rd_wide = w;
    @(posedge clk);
    #1;
    popped = 0;
    if (r && mcnt > 0) begin
      mlast = mq[0];
      if (w) begin
        for (int k = 0; k < 5; k++) mq[k] = mq[k+1];
        mcnt--; popped = 1;
      end
    end
    if (p) begin
      if (mcnt < 6) begin mq[mcnt] = d & 10'h3ff; mcnt++; end
      else movr = 1;
    end
    chk("R1 count", count, mcnt);
    chk("R5 empty", empty, mcnt == 0);
    chk("R5 full", full, mcnt == 6);
    chk("R3 rd_data", rd_data, mlast);
    chk("R6 overrun", overrun, movr);
    @(negedge clk);
    push_valid = 0; rd_en = 0; rd_wide = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 count", count, 0);
    chk("R9 empty", empty, 1);
    chk("R9 full", full, 0);
    chk("R9 overrun", overrun, 0);
    chk("R9 rd_data", rd_data, 0);
    rst_n = 1;
    // R7 read of empty buffer keeps rd_data and count
    step(0, 0, 1, 1);
    chk("R7 rd_data", rd_data, 0);
    chk("R7 count", count, 0);
    // fill past capacity
    for (int i = 0; i < 7; i++) step(1, 100 + i, 0, 0);
    chk("R1 capacity", count, 6);
    chk("R6 dropped", overrun, 1);
    // R4 byte peek twice: same head, count kept
    step(0, 0, 1, 0);
    chk("R4 head", rd_data, 100);
    step(0, 0, 1, 0);
    chk("R4 again", rd_data, 100);
    chk("R4 count", count, 6);
    // R8 push and pop together when full
    step(1, 900, 1, 1);
    chk("R8 count", count, 6);
    chk("R8 data", rd_data, 100);
    // R2 order of drain
    for (int i = 1; i < 6; i++) begin
      step(0, 0, 1, 1);
      chk("R2 order", rd_data, 100 + i);
    end
    step(0, 0, 1, 1);
    chk("R2 last", rd_data, 900);
    chk("R5 empty after drain", empty, 1);
    // sweep of all input combinations across phases
    for (int i = 0; i < 6000; i++) begin
      int ph = (i / 150) % 3;
      int h = (i * 13 + (i >> 3) * 7) % 8;
      bit p, r, w;
      case (ph)
        0: begin p = (h < 6); r = (h[0] == 1) && (h > 4); end
        1: begin p = (h < 2); r = (h > 1); end
        default: begin p = h[0]; r = h[1]; end
      endcase
      w = h[2] ^ i[4];
      step(p, (i * 37 + 5) & 1023, r, w);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule